// File: doc/BRIEF.md
# Power-On Reset Boot Sequencer

This block brings a small processor system out of power-on reset in a fixed order. Once the oscillator reports a stable clock, it keeps the internal power-on reset asserted for a set number of cycles. Engineering straps are latched while the supply is still ramping. The configuration-source strap is latched on the edge where the stretched reset releases. The sequencer then loads a configuration word. That word comes either from a serial-flash read handshake in 2-bit mode or from a hard-coded fallback constant, and the fallback is meant only for recovering blank flash.

After the configuration word is held, the sequencer waits for PLL lock, because the PLL settings come from that word. On the flash path it then waits for the platform clock and consumes preboot records. A preboot record is an address/data pair, and a terminator record ends the list. One of the records has to write the boot vector into the scratch address. The sequencer then drops the sleep indicator and, one cycle later, releases the core reset.

There are two failure cases. If the flash read times out, the sequencer parks with the reset-request output left inactive. If the record list ends without a boot-vector write, it parks with the reset request driven active.

Top module: `por_boot_seq`

## Requirements
- R1: While `rst_n` is low (synchronous), the block holds `phase_o`=0, `por_n_o`=0, `sleep_o`=1, `core_rst_n_o`=0, `rst_req_n_o`=1, `flash_rd_req_o`=0 and `pbi_ready_o`=0.
- R2: `por_n_o` stays low for exactly `STRETCH_CYC` (default 32) clock cycles after the edge that first samples `osc_stable_i` high, and rises on the next edge.
- R3: `eng_cfg_o` holds the value of `eng_strap_i` sampled on the same edge that first samples `osc_stable_i` high. Later changes to `eng_strap_i` have no effect on it.
- R4: `cfg_src_strap_i` is sampled only on the edge where `por_n_o` rises. A value of 1 selects the hard-coded configuration and 0 selects the flash fetch.
- R5: In the flash-fetch phase, `flash_rd_req_o` and `flash_x2_o` (2-bit read mode) are both high. The edge that samples `flash_rd_valid_i` high stores `flash_rd_data_i` in `cfg_word_o` and moves the block to the PLL phase.
- R6: The PLL phase is entered only after the configuration word is held. The block stays in it until `pll_lock_i` is sampled high, and `cfg_word_o` does not change after the fetch phase.
- R7: Preboot starts only after `plat_clk_ok_i` is sampled high, and `pbi_ready_o` is high only during preboot. A record whose address equals `SCRATCH_ADDR` loads `boot_vec_o`. A record to any other address leaves `boot_vec_o` unchanged, and its reset value is `DEFAULT_VEC`.
- R8: When a terminator record (`pbi_end_i`=1) is accepted after a boot-vector write, `sleep_o` falls on that edge and `core_rst_n_o` rises one edge later.
- R9: On the hard-coded path, `cfg_word_o` equals `HARD_CFG` and preboot is skipped: PLL lock leads straight to the wake phase, `pbi_ready_o` never rises, and `boot_vec_o` stays `DEFAULT_VEC`.
- R10: If no read completes within `FETCH_TIMEOUT` fetch cycles, the block parks in phase 8. In that phase `rst_req_n_o` stays 1, `core_rst_n_o` stays 0 and `sleep_o` stays 1.
- R11: A terminator accepted before any boot-vector write parks the block in phase 9. In that phase `rst_req_n_o` is 0, `core_rst_n_o` stays 0 and `sleep_o` stays 1.
- R12: `phase_o` encoding: 0 wait for oscillator, 1 reset stretch, 2 flash fetch, 3 PLL wait, 4 platform-clock wait, 5 preboot, 6 wake, 7 core running, 8 fetch failure, 9 missing boot vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| osc_stable_i | input | 1 | Oscillator/system clock reported stable |
| eng_strap_i | input | ENG_W | Engineering strap pins |
| cfg_src_strap_i | input | 1 | Configuration-source strap, 1 = hard-coded word |
| por_n_o | output | 1 | Stretched power-on reset, active low |
| eng_cfg_o | output | ENG_W | Latched engineering straps |
| flash_rd_req_o | output | 1 | Configuration read request to serial flash |
| flash_x2_o | output | 1 | Selects 2-bit read mode for the request |
| flash_rd_valid_i | input | 1 | Read data valid |
| flash_rd_data_i | input | CFG_W | Configuration word from flash |
| cfg_word_o | output | CFG_W | Held configuration word |
| pll_lock_i | input | 1 | System and core PLLs locked |
| plat_clk_ok_i | input | 1 | Platform clock available |
| pbi_valid_i | input | 1 | Preboot record valid |
| pbi_end_i | input | 1 | Record is the terminator |
| pbi_addr_i | input | PB_AW | Record address |
| pbi_data_i | input | PB_DW | Record data |
| pbi_ready_o | output | 1 | Preboot records accepted |
| boot_vec_o | output | PB_DW | Boot vector (scratch register) |
| sleep_o | output | 1 | Sleep indicator, high until wake |
| core_rst_n_o | output | 1 | Core reset, active low |
| rst_req_n_o | output | 1 | Reset request, active low |
| phase_o | output | 4 | Current boot phase (R12 encoding) |

## Verification
The bench counts the low cycles of the stretched reset after the oscillator edge, so a counter that is off by one shows up as 31 or 33. It moves the source strap to the fallback value only in the final stretch cycle, which tells the release-edge capture apart from an early or late sample. It runs the fetch timeout to completion and counts the fetch cycles, then checks that the reset request stays inactive. A design that asserted the request on a fetch failure, or that mixed up the two error cases, would be reported. A write to a non-scratch address, a list with no boot-vector write, and the fallback path are each driven to confirm that the vector and the preboot handshake are left alone and that the sleep indicator falls one cycle before the core is released.

// File: rtl/pbs_pkg.sv
// Package: shared phase encoding for the power-on boot sequencer.
// Assumes: phase codes are visible on phase_o and must not be renumbered.
package pbs_pkg;
    typedef enum logic [3:0] {
        PH_WAIT_OSC  = 4'd0,
        PH_STRETCH   = 4'd1,
        PH_FETCH     = 4'd2,
        PH_PLL       = 4'd3,
        PH_PRE_WAIT  = 4'd4,
        PH_PREBOOT   = 4'd5,
        PH_WAKE      = 4'd6,
        PH_RUN       = 4'd7,
        PH_ERR_FETCH = 4'd8,
        PH_ERR_VEC   = 4'd9
    } boot_phase_e;
endpackage

// File: rtl/pbs_stretch_timer.sv
// Module: counts the reset-stretch window.
// Purpose: done is high in the last of CYCLES consecutive cycles with run high.
// Assumes: run stays high until done has been seen; dropping run clears the count.
module pbs_stretch_timer #(
    parameter int CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    // Terminal count of the stretch window.
    assign done = run && (cnt == LAST);

    // Counts cycles spent in the window; clears outside it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (!done)
            cnt <= cnt + 1'b1;
    end

    // R2: the count never runs past the last value while the window is open
    p_cnt_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= LAST));
endmodule

// File: rtl/pbs_cfg_fetch.sv
// Module: holds the configuration word and times the flash read.
// Purpose: loads the word from the flash handshake or from the hard-coded
// constant, and flags a timeout when no read completes within TIMEOUT cycles.
// Assumes: active is high only during the fetch phase; load_hard and active
// are never high together.
module pbs_cfg_fetch #(
    parameter int          WORD_W    = 32,
    parameter int          TIMEOUT   = 4096,
    parameter logic [31:0] HARD_WORD = 32'h5A3C_0F81
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              load_hard,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_data,
    output logic              timeout,
    output logic [WORD_W-1:0] word
);
    localparam int TW = $clog2(TIMEOUT + 1);
    localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT - 1);

    logic [TW-1:0] tcnt;

    // Timeout fires in the last allowed cycle if data has not arrived.
    assign timeout = active && !rd_valid && (tcnt == T_LAST);

    // Fetch-cycle counter, idle outside the fetch phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tcnt <= '0;
        else if (!active)
            tcnt <= '0;
        else if (tcnt != T_LAST)
            tcnt <= tcnt + 1'b1;
    end

    // Configuration word register: flash data or fallback constant.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word <= '0;
        else if (load_hard)
            word <= HARD_WORD[WORD_W-1:0];
        else if (active && rd_valid)
            word <= rd_data;
    end

    // R5: the word only changes through a load
    p_word_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_hard && !(active && rd_valid)) |=> $stable(word));
endmodule

// File: rtl/pbs_preboot_scan.sv
// Module: consumes preboot address/data records.
// Purpose: captures the boot vector from a write to the scratch address and
// reports when the terminator record has been accepted.
// Assumes: one record per cycle; records are accepted only while active.
module pbs_preboot_scan #(
    parameter int              AW       = 32,
    parameter int              DW       = 32,
    parameter logic [AW-1:0]   SCRATCH  = '0,
    parameter logic [DW-1:0]   DEF_VEC  = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          rec_valid,
    input  logic          rec_end,
    input  logic [AW-1:0] rec_addr,
    input  logic [DW-1:0] rec_data,
    output logic          term,
    output logic          vec_seen,
    output logic [DW-1:0] boot_vec
);
    logic vec_hit;

    // Record accepted and addressed to the scratch register.
    assign vec_hit = active && rec_valid && !rec_end && (rec_addr == SCRATCH);
    // Terminator accepted this cycle.
    assign term    = active && rec_valid && rec_end;

    // Boot vector register and its written flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_vec <= DEF_VEC;
            vec_seen <= 1'b0;
        end else if (vec_hit) begin
            boot_vec <= rec_data;
            vec_seen <= 1'b1;
        end
    end

    // R7: a record to any other address leaves the vector alone
    p_vec_only_scratch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rec_valid && !rec_end && rec_addr != SCRATCH) |=> $stable(boot_vec));
endmodule

// File: rtl/por_boot_seq.sv
// Module: power-on reset boot sequencer (top).
// Purpose: steps through oscillator wait, reset stretch, configuration load,
// PLL lock, preboot writes, wake and core release, with two parking error
// phases for a failed fetch and a missing boot vector.
// Assumes: all inputs are synchronous to clk; rst_n is the synchronous
// power-on reset; the flash and PLLs sit behind simple level handshakes.
module por_boot_seq
    import pbs_pkg::*;
#(
    parameter int              STRETCH_CYC   = 32,
    parameter int              FETCH_TIMEOUT = 4096,
    parameter int              CFG_W         = 32,
    parameter int              ENG_W         = 4,
    parameter int              PB_AW         = 32,
    parameter int              PB_DW         = 32,
    parameter logic [PB_AW-1:0] SCRATCH_ADDR = 32'h0000_0600,
    parameter logic [PB_DW-1:0] DEFAULT_VEC  = 32'h0000_1000,
    parameter logic [31:0]     HARD_CFG      = 32'h5A3C_0F81
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_stable_i,
    input  logic [ENG_W-1:0] eng_strap_i,
    input  logic             cfg_src_strap_i,
    output logic             por_n_o,
    output logic [ENG_W-1:0] eng_cfg_o,
    output logic             flash_rd_req_o,
    output logic             flash_x2_o,
    input  logic             flash_rd_valid_i,
    input  logic [CFG_W-1:0] flash_rd_data_i,
    output logic [CFG_W-1:0] cfg_word_o,
    input  logic             pll_lock_i,
    input  logic             plat_clk_ok_i,
    input  logic             pbi_valid_i,
    input  logic             pbi_end_i,
    input  logic [PB_AW-1:0] pbi_addr_i,
    input  logic [PB_DW-1:0] pbi_data_i,
    output logic             pbi_ready_o,
    output logic [PB_DW-1:0] boot_vec_o,
    output logic             sleep_o,
    output logic             core_rst_n_o,
    output logic             rst_req_n_o,
    output logic [3:0]       phase_o
);
    boot_phase_e state, state_nx;
    logic stretch_done, leave_stretch, fetch_timeout;
    logic pb_term, vec_seen, hard_q;

    assign leave_stretch = (state == PH_STRETCH) && stretch_done;

    pbs_stretch_timer #(.CYCLES(STRETCH_CYC)) u_stretch (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state == PH_STRETCH),
        .done (stretch_done)
    );

    pbs_cfg_fetch #(
        .WORD_W   (CFG_W),
        .TIMEOUT  (FETCH_TIMEOUT),
        .HARD_WORD(HARD_CFG)
    ) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (state == PH_FETCH),
        .load_hard(leave_stretch && cfg_src_strap_i),
        .rd_valid (flash_rd_valid_i),
        .rd_data  (flash_rd_data_i),
        .timeout  (fetch_timeout),
        .word     (cfg_word_o)
    );

    pbs_preboot_scan #(
        .AW     (PB_AW),
        .DW     (PB_DW),
        .SCRATCH(SCRATCH_ADDR),
        .DEF_VEC(DEFAULT_VEC)
    ) u_preboot (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (state == PH_PREBOOT),
        .rec_valid(pbi_valid_i),
        .rec_end  (pbi_end_i),
        .rec_addr (pbi_addr_i),
        .rec_data (pbi_data_i),
        .term     (pb_term),
        .vec_seen (vec_seen),
        .boot_vec (boot_vec_o)
    );

    // Next-phase selection in the fixed boot order.
    always_comb begin
        state_nx = state;
        unique case (state)
            PH_WAIT_OSC: if (osc_stable_i) state_nx = PH_STRETCH;
            PH_STRETCH:  if (stretch_done) state_nx = cfg_src_strap_i ? PH_PLL : PH_FETCH;
            PH_FETCH: begin
                if (flash_rd_valid_i)   state_nx = PH_PLL;
                else if (fetch_timeout) state_nx = PH_ERR_FETCH;
            end
            PH_PLL:      if (pll_lock_i) state_nx = hard_q ? PH_WAKE : PH_PRE_WAIT;
            PH_PRE_WAIT: if (plat_clk_ok_i) state_nx = PH_PREBOOT;
            PH_PREBOOT:  if (pb_term) state_nx = vec_seen ? PH_WAKE : PH_ERR_VEC;
            PH_WAKE:     state_nx = PH_RUN;
            default:     state_nx = state;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PH_WAIT_OSC;
        else        state <= state_nx;
    end

    // Engineering straps follow the pins until the oscillator is seen stable.
    always_ff @(posedge clk) begin
        if (!rst_n)                   eng_cfg_o <= '0;
        else if (state == PH_WAIT_OSC) eng_cfg_o <= eng_strap_i;
    end

    // Source strap latched on the edge the stretched reset releases.
    always_ff @(posedge clk) begin
        if (!rst_n)             hard_q <= 1'b0;
        else if (leave_stretch) hard_q <= cfg_src_strap_i;
    end

    // Phase-decoded outputs.
    assign por_n_o        = !(state == PH_WAIT_OSC || state == PH_STRETCH);
    assign flash_rd_req_o = (state == PH_FETCH);
    assign flash_x2_o     = (state == PH_FETCH);
    assign pbi_ready_o    = (state == PH_PREBOOT);
    assign sleep_o        = !(state == PH_WAKE || state == PH_RUN);
    assign core_rst_n_o   = (state == PH_RUN);
    assign rst_req_n_o    = (state != PH_ERR_VEC);
    assign phase_o        = state;

    // R2: reset releases only at the end of the stretch window
    p_por_after_stretch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(por_n_o) |-> $past(stretch_done));
    // R3: engineering straps are frozen once the oscillator is stable
    p_eng_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PH_WAIT_OSC) |=> $stable(eng_cfg_o));
    // R6: configuration word is held from the PLL phase onward
    p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {PH_PLL, PH_PRE_WAIT, PH_PREBOOT, PH_WAKE, PH_RUN,
                       PH_ERR_FETCH, PH_ERR_VEC}) |=> $stable(cfg_word_o));
    // R6: no progress without PLL lock
    p_pll_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_PLL && !pll_lock_i) |=> (state == PH_PLL));
    // R8: sleep indicator is already low when the core is released
    p_sleep_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n_o) |-> $past(!sleep_o));
    // R7: flash-path core release requires a boot-vector write
    p_vec_before_core_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(core_rst_n_o) && !hard_q) |-> vec_seen);
    // R10: a failed fetch never raises the reset request nor frees the core
    p_fetch_fail_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_ERR_FETCH) |-> (rst_req_n_o && !core_rst_n_o && sleep_o));
endmodule

// File: tb/por_boot_seq_tb_top.sv
module por_boot_seq_tb_top;
    localparam int          TO       = 24;
    localparam logic [31:0] SCR      = 32'h0000_0600;
    localparam logic [31:0] DEFV     = 32'h0000_1000;
    localparam logic [31:0] HARDW    = 32'h5A3C_0F81;

    // Scenario table: [71] hard strap, [70] fetch succeeds, [69] vector written,
    // [63:32] flash config word, [31:0] boot vector to write.
    localparam logic [71:0] SCEN [0:4] = '{
        {1'b0, 1'b1, 1'b1, 5'd0, 32'h1234_5678, 32'h8000_0040},
        {1'b1, 1'b0, 1'b0, 5'd0, 32'h0000_0000, 32'h0000_0000},
        {1'b0, 1'b0, 1'b0, 5'd0, 32'h0000_0000, 32'h0000_0000},
        {1'b0, 1'b1, 1'b0, 5'd0, 32'hCAFE_0001, 32'h0000_0000},
        {1'b0, 1'b1, 1'b1, 5'd0, 32'h0F0F_F0F0, 32'hFFFF_FFFC}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc = 1'b0, src = 1'b0, fvalid = 1'b0, lock = 1'b0, plat = 1'b0;
    logic pvalid = 1'b0, pend = 1'b0;
    logic [3:0]  eng = '0;
    logic [31:0] fdata = '0, paddr = '0, pdata = '0;
    logic por_n, flash_req, flash_x2, pready, sleep, core_n, rreq_n;
    logic [3:0]  eng_cfg, phase;
    logic [31:0] cfg_word, bvec;
    int checks = 0, fails = 0;
    logic ready_seen = 1'b0;

    always #10 clk = ~clk;

    por_boot_seq #(.FETCH_TIMEOUT(TO)) dut_i (
        .clk(clk), .rst_n(rst_n), .osc_stable_i(osc), .eng_strap_i(eng),
        .cfg_src_strap_i(src), .por_n_o(por_n), .eng_cfg_o(eng_cfg),
        .flash_rd_req_o(flash_req), .flash_x2_o(flash_x2),
        .flash_rd_valid_i(fvalid), .flash_rd_data_i(fdata), .cfg_word_o(cfg_word),
        .pll_lock_i(lock), .plat_clk_ok_i(plat), .pbi_valid_i(pvalid),
        .pbi_end_i(pend), .pbi_addr_i(paddr), .pbi_data_i(pdata),
        .pbi_ready_o(pready), .boot_vec_o(bvec), .sleep_o(sleep),
        .core_rst_n_o(core_n), .rst_req_n_o(rreq_n), .phase_o(phase)
    );

    always @(posedge clk) if (pready) ready_seen <= 1'b1;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic reset_dut();
        osc = 0; src = 0; fvalid = 0; lock = 0; plat = 0; pvalid = 0; pend = 0;
        eng = '0; fdata = '0; paddr = '0; pdata = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        ready_seen = 1'b0;
        chk("R1", "phase", 32'(phase), 32'd0);
        chk("R1", "por_n", 32'(por_n), 32'd0);
        chk("R1", "sleep", 32'(sleep), 32'd1);
        chk("R1", "core_n", 32'(core_n), 32'd0);
        chk("R1", "rreq_n", 32'(rreq_n), 32'd1);
        chk("R1", "flash_req", 32'(flash_req), 32'd0);
        chk("R1", "pready", 32'(pready), 32'd0);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic run_boot(input logic [71:0] v, input int idx);
        logic hard, ok, wvec;
        logic [31:0] cw, vec;
        logic [3:0]  eng_a;
        int lows, fc;
        hard = v[71]; ok = v[70]; wvec = v[69]; cw = v[63:32]; vec = v[31:0];
        eng_a = 4'(4'h9 ^ idx);
        reset_dut();
        chk("R12", "phase wait-osc", 32'(phase), 32'd0);
        eng = eng_a; osc = 1; src = !hard;
        @(negedge clk);
        eng = ~eng_a;
        lows = 0;
        while (por_n == 1'b0 && lows < 100) begin
            lows++;
            src = (lows == 32) ? hard : !hard;   // R4: only the release edge counts
            @(negedge clk);
        end
        src = !hard;
        chk("R2", "stretch length", 32'(lows), 32'd32);
        chk("R3", "eng straps", 32'(eng_cfg), 32'(eng_a));
        chk("R4", "source selection", 32'(phase), hard ? 32'd3 : 32'd2);
        if (hard) begin
            chk("R9", "hard config", cw == cw ? cfg_word : 32'd0, HARDW);
        end else begin
            chk("R5", "flash req", 32'(flash_req), 32'd1);
            chk("R5", "2-bit mode", 32'(flash_x2), 32'd1);
            if (ok) begin
                repeat (2) @(negedge clk);
                chk("R5", "still fetching", 32'(phase), 32'd2);
                fvalid = 1; fdata = cw;
                @(negedge clk);
                fvalid = 0; fdata = '0;
                chk("R5", "to PLL", 32'(phase), 32'd3);
                chk("R5", "config word", cfg_word, cw);
                chk("R5", "req dropped", 32'(flash_req), 32'd0);
            end else begin
                fc = 1;
                @(negedge clk);
                while (phase == 4'd2 && fc < 1000) begin
                    fc++;
                    @(negedge clk);
                end
                chk("R10", "fetch cycles", 32'(fc), 32'(TO));
                repeat (4) @(negedge clk);
                chk("R10", "parked", 32'(phase), 32'd8);
                chk("R10", "no reset request", 32'(rreq_n), 32'd1);
                chk("R10", "core held", 32'(core_n), 32'd0);
                chk("R10", "still asleep", 32'(sleep), 32'd1);
                return;
            end
        end
        repeat (3) @(negedge clk);
        chk("R6", "waits for lock", 32'(phase), 32'd3);
        lock = 1;
        @(negedge clk);
        if (hard) begin
            chk("R9", "skips preboot", 32'(phase), 32'd6);
            chk("R8", "sleep low", 32'(sleep), 32'd0);
            chk("R8", "core still held", 32'(core_n), 32'd0);
            @(negedge clk);
            chk("R8", "core released", 32'(core_n), 32'd1);
            chk("R9", "default vector", bvec, DEFV);
            chk("R9", "no preboot handshake", 32'(ready_seen), 32'd0);
            chk("R9", "word held", cfg_word, HARDW);
            return;
        end
        chk("R7", "platform clock wait", 32'(phase), 32'd4);
        repeat (2) @(negedge clk);
        chk("R7", "not ready yet", 32'(pready), 32'd0);
        plat = 1;
        @(negedge clk);
        chk("R7", "preboot", 32'(phase), 32'd5);
        chk("R7", "ready", 32'(pready), 32'd1);
        pvalid = 1; paddr = SCR + 32'd4; pdata = ~vec;
        @(negedge clk);
        pvalid = 0;
        chk("R7", "other address ignored", bvec, DEFV);
        if (wvec) begin
            pvalid = 1; paddr = SCR; pdata = vec;
            @(negedge clk);
            pvalid = 0;
            chk("R7", "vector written", bvec, vec);
        end
        pvalid = 1; pend = 1; paddr = '0; pdata = '0;
        @(negedge clk);
        pvalid = 0; pend = 0;
        if (wvec) begin
            chk("R8", "wake phase", 32'(phase), 32'd6);
            chk("R8", "sleep low first", 32'(sleep), 32'd0);
            chk("R8", "core held in wake", 32'(core_n), 32'd0);
            @(negedge clk);
            chk("R8", "run phase", 32'(phase), 32'd7);
            chk("R8", "core released", 32'(core_n), 32'd1);
            chk("R6", "word kept", cfg_word, cw);
        end else begin
            chk("R11", "parked", 32'(phase), 32'd9);
            chk("R11", "reset request", 32'(rreq_n), 32'd0);
            chk("R11", "core held", 32'(core_n), 32'd0);
            chk("R11", "asleep", 32'(sleep), 32'd1);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int i = 0; i < 5; i++) run_boot(SCEN[i], i);
        // Directed: reset during the stretch window returns to the reset state (R1)
        reset_dut();
        osc = 1;
        repeat (10) @(negedge clk);
        chk("R2", "still stretching", 32'(por_n), 32'd0);
        rst_n = 0;
        @(negedge clk);
        chk("R1", "phase after mid reset", 32'(phase), 32'd0);
        chk("R1", "por_n after mid reset", 32'(por_n), 32'd0);
        // Directed: oscillator never stable keeps the block waiting (R2)
        reset_dut();
        repeat (50) @(negedge clk);
        chk("R2", "no release without osc", 32'(por_n), 32'd0);
        chk("R12", "waiting phase", 32'(phase), 32'd0);
        summary();
    end
endmodule